// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a direct-mapped data cache that sits between one processor port and a memory port that moves whole lines. Stores use a write-back, write-allocate policy. Each line has a valid flag, a dirty flag, a tag and 64 bytes of data. The processor issues word loads and stores with a valid/ready handshake. Loads return their data one cycle after they are accepted. The memory side sees only full-line reads, which fill lines, and full-line writes, which return dirty victims to memory.

A small controller handles a miss in a fixed order. It compares the tag, writes back the victim if the victim is dirty, fetches the new line, and then lets the stalled access complete from the refreshed line. The address is split into a tag, a line index, and a 6-bit byte offset within the line. The line count and the address and word widths are parameters.

Top module: `wb_cache`

## Requirements
- R1: After reset every line is invalid. With no request, `cpu_req_ready_o`, `mem_req_valid_o` and `cpu_rsp_valid_o` are low, and the first access to any index misses.
- R2: A load miss issues one memory read of the line address, which is the request address with bits [5:0] cleared. It returns the word only after the fill. Word k of a line occupies line bits [32k+31:32k] and is selected by address bits [5:2].
- R3: A load hit is accepted in the cycle it is presented. Its data appears on `cpu_rsp_rdata_o` with `cpu_rsp_valid_o` high in the next cycle, and it causes no memory request.
- R4: A store hit updates only the addressed word in the cache, marks the line dirty, and causes no memory request.
- R5: A store miss first fills the line from memory, then writes the word into the cache only. No memory write is issued for the store itself.
- R6: A newly filled line is clean. Replacing a line that was filled by a load and never stored to issues no write-back.
- R7: Replacing a dirty line first issues one memory write. Its address is the victim's tag and index with offset zero, and it carries the whole 64-byte line, including the words that were never stored to.
- R8: The fill request for the new line is issued only after the memory has acknowledged the victim write-back on `mem_rsp_valid_i`.
- R9: `cpu_req_ready_o` stays low from the moment a miss is detected until the fill completes. The same held request is then accepted as a hit.
- R10: While `mem_req_valid_o` is high and `mem_req_ready_i` is low, the memory request's valid, direction and address hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_valid_i | input | 1 | Processor request present |
| cpu_req_ready_o | output | 1 | Request accepted this cycle (hit in idle) |
| cpu_req_we_i | input | 1 | 1 = store, 0 = load |
| cpu_req_addr_i | input | ADDR_W | Byte address |
| cpu_req_wdata_i | input | WORD_W | Store data |
| cpu_rsp_valid_o | output | 1 | Load data valid |
| cpu_rsp_rdata_o | output | WORD_W | Load data |
| mem_req_valid_o | output | 1 | Memory line request present |
| mem_req_ready_i | input | 1 | Memory accepts request |
| mem_req_we_o | output | 1 | 1 = line write-back, 0 = line fill |
| mem_req_addr_o | output | ADDR_W | Line-aligned address |
| mem_req_wdata_o | output | 512 | Write-back line data |
| mem_rsp_valid_i | input | 1 | Fill data valid or write-back acknowledged |
| mem_rsp_rdata_i | input | 512 | Fill line data |

## Verification
A wrong valid flag or tag shows up immediately at the ports as a stall where a hit was due, or as a missing stall. A lost or spurious dirty flag stays hidden until that index is next replaced. Its symptom is then a missing or extra memory write, or a write-back whose line differs from the architectural line image. A corrupted data word surfaces on the next load to that word, or in the write-back payload. The bench therefore forces frequent replacement on a four-line configuration, so stale state is exposed within a few accesses.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WB_REQ,
    ST_WB_WAIT,
    ST_FILL_REQ,
    ST_FILL_WAIT
  } wbc_state_e;
endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store #(
  parameter int NUM_LINES = 64,
  parameter int TAG_W     = 20,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             valid_o,
  output logic             dirty_o,
  output logic [TAG_W-1:0] tag_o,
  input  logic             install_i,
  input  logic [IDX_W-1:0] install_idx_i,
  input  logic [TAG_W-1:0] install_tag_i,
  input  logic             drop_i,
  input  logic [IDX_W-1:0] drop_idx_i,
  input  logic             mark_dirty_i,
  input  logic [IDX_W-1:0] mark_idx_i
);
  logic [NUM_LINES-1:0] valid_q;
  logic [NUM_LINES-1:0] dirty_q;
  logic [TAG_W-1:0]     tag_q [NUM_LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (drop_i) begin
        valid_q[drop_idx_i] <= 1'b0;
        dirty_q[drop_idx_i] <= 1'b0;
      end
      if (install_i) begin
        valid_q[install_idx_i] <= 1'b1;
        dirty_q[install_idx_i] <= 1'b0;
      end
      if (mark_dirty_i) dirty_q[mark_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (install_i) tag_q[install_idx_i] <= install_tag_i;
  end

  assign valid_o = valid_q[rd_idx_i];
  assign dirty_o = dirty_q[rd_idx_i];
  assign tag_o   = tag_q[rd_idx_i];
endmodule

// File: rtl/wbc_data_store.sv
module wbc_data_store #(
  parameter int NUM_LINES = 64,
  parameter int LINE_W    = 512,
  parameter int WORD_W    = 32,
  localparam int IDX_W    = $clog2(NUM_LINES),
  localparam int WOFF_W   = $clog2(LINE_W / WORD_W)
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [LINE_W-1:0] line_o,
  input  logic              fill_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [LINE_W-1:0] fill_line_i,
  input  logic              word_we_i,
  input  logic [IDX_W-1:0]  word_idx_i,
  input  logic [WOFF_W-1:0] word_off_i,
  input  logic [WORD_W-1:0] word_i
);
  logic [LINE_W-1:0] line_q [NUM_LINES];

  always_ff @(posedge clk_i) begin
    if (fill_i) line_q[fill_idx_i] <= fill_line_i;
    else if (word_we_i) line_q[word_idx_i][word_off_i*WORD_W +: WORD_W] <= word_i;
  end

  assign line_o = line_q[rd_idx_i];
endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
  import wbc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic       hit_i,
  input  logic       victim_dirty_i,
  input  logic       mem_req_ready_i,
  input  logic       mem_rsp_valid_i,
  output wbc_state_e state_o
);
  wbc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:
        if (req_valid_i && !hit_i) state_d = victim_dirty_i ? ST_WB_REQ : ST_FILL_REQ;
      ST_WB_REQ:    if (mem_req_ready_i) state_d = ST_WB_WAIT;
      ST_WB_WAIT:   if (mem_rsp_valid_i) state_d = ST_FILL_REQ;
      ST_FILL_REQ:  if (mem_req_ready_i) state_d = ST_FILL_WAIT;
      ST_FILL_WAIT: if (mem_rsp_valid_i) state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/wb_cache.sv
module wb_cache
  import wbc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int WORD_W    = 32,
  parameter int NUM_LINES = 64,
  localparam int OFF_W    = 6,
  localparam int LINE_W   = (1 << OFF_W) * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_valid_i,
  output logic              cpu_req_ready_o,
  input  logic              cpu_req_we_i,
  input  logic [ADDR_W-1:0] cpu_req_addr_i,
  input  logic [WORD_W-1:0] cpu_req_wdata_i,
  output logic              cpu_rsp_valid_o,
  output logic [WORD_W-1:0] cpu_rsp_rdata_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic              mem_req_we_o,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  output logic [LINE_W-1:0] mem_req_wdata_o,
  input  logic              mem_rsp_valid_i,
  input  logic [LINE_W-1:0] mem_rsp_rdata_i
);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int BOFF_W = $clog2(WORD_W / 8);
  localparam int WOFF_W = OFF_W - BOFF_W;

  wbc_state_e state;

  logic [IDX_W-1:0]  req_idx, miss_idx_q, rd_idx;
  logic [TAG_W-1:0]  req_tag, miss_tag_q, line_tag;
  logic [WOFF_W-1:0] req_woff;
  logic              line_valid, line_dirty, hit, idle;
  logic              accept, miss_start;
  logic [LINE_W-1:0] line_data;
  logic              rsp_valid_q;
  logic [WORD_W-1:0] rsp_rdata_q;

  assign req_idx  = cpu_req_addr_i[OFF_W +: IDX_W];
  assign req_tag  = cpu_req_addr_i[ADDR_W-1 -: TAG_W];
  assign req_woff = cpu_req_addr_i[BOFF_W +: WOFF_W];

  assign idle       = (state == ST_IDLE);
  assign rd_idx     = idle ? req_idx : miss_idx_q;
  assign hit        = line_valid && (line_tag == req_tag);
  assign accept     = idle && cpu_req_valid_i && hit;
  assign miss_start = idle && cpu_req_valid_i && !hit;

  wbc_ctrl u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (cpu_req_valid_i),
    .hit_i          (hit),
    .victim_dirty_i (line_valid && line_dirty),
    .mem_req_ready_i(mem_req_ready_i),
    .mem_rsp_valid_i(mem_rsp_valid_i),
    .state_o        (state)
  );

  // a clean victim is dropped at miss detection, a dirty one after its write-back is acknowledged
  logic drop_en;
  logic fill_en;
  assign drop_en = (miss_start && line_valid && !line_dirty)
                || (state == ST_WB_WAIT && mem_rsp_valid_i);
  assign fill_en = (state == ST_FILL_WAIT) && mem_rsp_valid_i;

  wbc_tag_store #(
    .NUM_LINES(NUM_LINES),
    .TAG_W    (TAG_W)
  ) u_tags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_idx_i     (rd_idx),
    .valid_o      (line_valid),
    .dirty_o      (line_dirty),
    .tag_o        (line_tag),
    .install_i    (fill_en),
    .install_idx_i(miss_idx_q),
    .install_tag_i(miss_tag_q),
    .drop_i       (drop_en),
    .drop_idx_i   (rd_idx),
    .mark_dirty_i (accept && cpu_req_we_i),
    .mark_idx_i   (req_idx)
  );

  wbc_data_store #(
    .NUM_LINES(NUM_LINES),
    .LINE_W   (LINE_W),
    .WORD_W   (WORD_W)
  ) u_data (
    .clk_i      (clk_i),
    .rd_idx_i   (rd_idx),
    .line_o     (line_data),
    .fill_i     (fill_en),
    .fill_idx_i (miss_idx_q),
    .fill_line_i(mem_rsp_rdata_i),
    .word_we_i  (accept && cpu_req_we_i),
    .word_idx_i (req_idx),
    .word_off_i (req_woff),
    .word_i     (cpu_req_wdata_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      miss_idx_q <= '0;
      miss_tag_q <= '0;
    end else if (miss_start) begin
      miss_idx_q <= req_idx;
      miss_tag_q <= req_tag;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= accept && !cpu_req_we_i;
      if (accept && !cpu_req_we_i) rsp_rdata_q <= line_data[req_woff*WORD_W +: WORD_W];
    end
  end

  logic wb_phase;
  assign wb_phase = (state == ST_WB_REQ) || (state == ST_WB_WAIT);

  assign cpu_req_ready_o = idle && hit;
  assign cpu_rsp_valid_o = rsp_valid_q;
  assign cpu_rsp_rdata_o = rsp_rdata_q;
  assign mem_req_valid_o = (state == ST_WB_REQ) || (state == ST_FILL_REQ);
  assign mem_req_we_o    = (state == ST_WB_REQ);
  assign mem_req_addr_o  = {(wb_phase ? line_tag : miss_tag_q), miss_idx_q, {OFF_W{1'b0}}};
  assign mem_req_wdata_o = line_data;

  logic unused_bits;
  assign unused_bits = ^{cpu_req_addr_i[BOFF_W > 0 ? BOFF_W-1 : 0], wb_phase};
endmodule

// File: rtl/wbc_checker.sv
module wbc_checker #(
  parameter int ADDR_W    = 32,
  parameter int WORD_W    = 32,
  localparam int LINE_W   = 512
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_valid_i,
  input logic              cpu_req_ready_o,
  input logic              cpu_req_we_i,
  input logic [ADDR_W-1:0] cpu_req_addr_i,
  input logic [WORD_W-1:0] cpu_req_wdata_i,
  input logic              cpu_rsp_valid_o,
  input logic [WORD_W-1:0] cpu_rsp_rdata_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic              mem_req_we_o,
  input logic [ADDR_W-1:0] mem_req_addr_o,
  input logic [LINE_W-1:0] mem_req_wdata_o,
  input logic              mem_rsp_valid_i,
  input logic [LINE_W-1:0] mem_rsp_rdata_i
);
  logic wb_pend_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wb_pend_q <= 1'b0;
    else if (mem_req_valid_o && mem_req_ready_i && mem_req_we_o) wb_pend_q <= 1'b1;
    else if (mem_rsp_valid_i) wb_pend_q <= 1'b0;
  end

  p_idle_after_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !mem_req_valid_o && !cpu_rsp_valid_o);

  p_line_aligned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> (mem_req_addr_o[5:0] == 6'd0));

  p_hit_no_mem_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_ready_o |-> !mem_req_valid_o);

  p_load_rsp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_valid_i && cpu_req_ready_o && !cpu_req_we_i) |=> cpu_rsp_valid_o);

  p_store_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_valid_i && cpu_req_ready_o && cpu_req_we_i) |=> !mem_req_valid_o && !cpu_rsp_valid_o);

  p_fill_after_wb_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_we_o) |-> !wb_pend_q);

  p_stall_during_mem_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o || wb_pend_q) |-> !cpu_req_ready_o);

  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=>
      (mem_req_valid_o && $stable(mem_req_we_o) && $stable(mem_req_addr_o)));
endmodule

bind wb_cache wbc_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_wbc_checker (.*);

// File: tb/wb_cache_bench.sv
module wb_cache_bench;
  localparam int ADDR_W = 16;
  localparam int WORD_W = 32;
  localparam int NLINES = 4;
  localparam int LINE_W = 512;
  localparam int NIMG   = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cpu_req_valid_i = 1'b0;
  logic              cpu_req_ready_o;
  logic              cpu_req_we_i = 1'b0;
  logic [ADDR_W-1:0] cpu_req_addr_i = '0;
  logic [WORD_W-1:0] cpu_req_wdata_i = '0;
  logic              cpu_rsp_valid_o;
  logic [WORD_W-1:0] cpu_rsp_rdata_o;
  logic              mem_req_valid_o;
  logic              mem_req_ready_i = 1'b0;
  logic              mem_req_we_o;
  logic [ADDR_W-1:0] mem_req_addr_o;
  logic [LINE_W-1:0] mem_req_wdata_o;
  logic              mem_rsp_valid_i = 1'b0;
  logic [LINE_W-1:0] mem_rsp_rdata_i = '0;

  always #2 clk = ~clk;

  wb_cache #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .NUM_LINES(NLINES)) u_wb_cache (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_valid_i, .cpu_req_ready_o, .cpu_req_we_i, .cpu_req_addr_i, .cpu_req_wdata_i,
    .cpu_rsp_valid_o, .cpu_rsp_rdata_o,
    .mem_req_valid_o, .mem_req_ready_i, .mem_req_we_o, .mem_req_addr_o, .mem_req_wdata_o,
    .mem_rsp_valid_i, .mem_rsp_rdata_i
  );

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [LINE_W-1:0] mem_img [NIMG];
  logic [LINE_W-1:0] ref_img [NIMG];

  int                n_ev;
  bit                ev_we   [8];
  logic [ADDR_W-1:0] ev_addr [8];
  logic [LINE_W-1:0] ev_line [8];
  int                ev_seen [8];
  int                ev_done [8];

  bit             pv [NLINES];
  bit             pd [NLINES];
  int             ptag [NLINES];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model: variable accept and response latency
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid_o) begin
        automatic logic [ADDR_W-1:0] a = mem_req_addr_o;
        automatic bit w = mem_req_we_o;
        automatic logic [LINE_W-1:0] d = mem_req_wdata_o;
        automatic int seen = cyc;
        automatic int k = n_ev;
        repeat (int'(a[7:6]) % 3) begin
          @(negedge clk);
          check(mem_req_valid_o && mem_req_addr_o == a && mem_req_we_o == w,
                "R10", "request held while not ready", 32'(mem_req_addr_o), 32'(a));
        end
        mem_req_ready_i = 1'b1;
        @(negedge clk);
        mem_req_ready_i = 1'b0;
        if (k < 8) begin
          ev_we[k] = w; ev_addr[k] = a; ev_line[k] = d; ev_seen[k] = seen;
        end
        n_ev = k + 1;
        if (w) mem_img[a[11:6]] = d;
        repeat (1 + int'(a[8])) @(negedge clk);
        mem_rsp_valid_i = 1'b1;
        mem_rsp_rdata_i = w ? '0 : mem_img[a[11:6]];
        @(negedge clk);
        if (k < 8) ev_done[k] = cyc;
        mem_rsp_valid_i = 1'b0;
        mem_rsp_rdata_i = '0;
      end
    end
  end

  task automatic access(input bit we, input int tag, input int idx, input int wrd,
                        input logic [31:0] wdata);
    automatic logic [ADDR_W-1:0] a = ADDR_W'((tag << 8) | (idx << 6) | (wrd << 2));
    automatic int lnum = (tag << 2) | idx;
    automatic bit hit = pv[idx] && ptag[idx] == tag;
    automatic bit do_wb = !hit && pv[idx] && pd[idx];
    automatic int vline = (ptag[idx] << 2) | idx;
    automatic int stall = 0;
    automatic int exp_ev = hit ? 0 : (do_wb ? 2 : 1);
    automatic int fi = do_wb ? 1 : 0;
    automatic string rq = we ? "R5" : "R2";
    n_ev = 0;
    @(negedge clk);
    cpu_req_valid_i = 1'b1;
    cpu_req_we_i    = we;
    cpu_req_addr_i  = a;
    cpu_req_wdata_i = wdata;
    #1;
    while (!cpu_req_ready_o && stall < 500) begin
      @(negedge clk); #1;
      stall++;
    end
    check((stall > 0) == !hit, "R9", "stall iff miss", 32'(stall), 32'(!hit));
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid_i = 1'b0;
    if (!we) begin
      check(cpu_rsp_valid_o == 1'b1, hit ? "R3" : "R2", "load rsp valid", 32'(cpu_rsp_valid_o), 32'd1);
      check(cpu_rsp_rdata_o == ref_img[lnum][wrd*32 +: 32], hit ? "R3" : "R2", "load data",
            cpu_rsp_rdata_o, ref_img[lnum][wrd*32 +: 32]);
    end else begin
      check(cpu_rsp_valid_o == 1'b0, "R4", "no rsp for store", 32'(cpu_rsp_valid_o), 32'd0);
      ref_img[lnum][wrd*32 +: 32] = wdata;
    end
    check(n_ev == exp_ev, hit ? (we ? "R4" : "R3") : (do_wb ? "R7" : "R6"),
          "memory request count", 32'(n_ev), 32'(exp_ev));
    if (n_ev == exp_ev && !hit) begin
      if (do_wb) begin
        check(ev_we[0] == 1'b1 && ev_addr[0] == ADDR_W'(vline << 6), "R7", "write-back address",
              32'(ev_addr[0]), 32'(vline << 6));
        check(ev_line[0] == ref_img[vline], "R7", "write-back full line",
              ev_line[0][31:0], ref_img[vline][31:0]);
        check(ev_seen[1] >= ev_done[0], "R8", "fill after write-back ack",
              32'(ev_seen[1]), 32'(ev_done[0]));
      end
      check(ev_we[fi] == 1'b0 && ev_addr[fi] == ADDR_W'(lnum << 6), rq, "fill read address",
            32'(ev_addr[fi]), 32'(lnum << 6));
    end
    if (!hit) pd[idx] = we;
    else      pd[idx] = pd[idx] | we;
    pv[idx] = 1'b1;
    ptag[idx] = tag;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    automatic logic [31:0] r = 32'h1d2c_3b4a;
    for (int k = 0; k < NIMG; k++)
      for (int w = 0; w < 16; w++) begin
        mem_img[k][w*32 +: 32] = 32'h5A00_0000 ^ (k << 16) ^ (w * 32'h0101);
        ref_img[k][w*32 +: 32] = 32'h5A00_0000 ^ (k << 16) ^ (w * 32'h0101);
      end
    for (int i = 0; i < NLINES; i++) begin pv[i] = 0; pd[i] = 0; ptag[i] = 0; end
    repeat (3) @(negedge clk);
    check(cpu_req_ready_o == 0 && mem_req_valid_o == 0 && cpu_rsp_valid_o == 0, "R1",
          "outputs in reset", {29'd0, cpu_req_ready_o, mem_req_valid_o, cpu_rsp_valid_o}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(cpu_req_ready_o == 0 && mem_req_valid_o == 0, "R1", "idle after reset",
          {30'd0, cpu_req_ready_o, mem_req_valid_o}, 32'd0);
    // R1: every index misses once after reset
    for (int i = 0; i < NLINES; i++) begin
      access(0, 0, i, i, 0);
      check(n_ev == 1, "R1", "cold miss", 32'(n_ev), 32'd1);
    end
    // directed: hits, store hit, dirty eviction, clean eviction, store miss
    access(0, 0, 1, 3, 0);
    access(1, 0, 1, 5, 32'hCAFE_0005);
    access(0, 0, 1, 5, 0);
    access(0, 3, 1, 2, 0);
    access(0, 0, 1, 5, 0);
    access(0, 7, 1, 0, 0);
    access(1, 9, 2, 15, 32'hBEEF_000F);
    access(0, 2, 2, 15, 0);
    access(0, 9, 2, 15, 0);
    // near-exhaustive sweep over tags, indices, words and directions
    for (int n = 0; n < 600; n++) begin
      r ^= r << 13; r ^= r >> 17; r ^= r << 5;
      access(r[12], int'(r[3:0]) % 6, int'(r[5:4]), int'(r[11:8]), r);
    end
    // flush all lines by conflicting loads, exposing every dirty line
    for (int i = 0; i < NLINES; i++) access(0, 15, i, 0, 0);
    for (int i = 0; i < NLINES; i++) access(0, 14, i, 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule